// File: doc/BRIEF.md
# Qualified Non-Maskable Interrupt Detector

This block takes one asynchronous non-maskable interrupt line and turns it into a single, clean request for the processor. The line first passes through a synchronizer. An inactive-to-active transition of the synchronized level opens a qualification window. The request is latched only if the level then stays active for a programmable number of consecutive clock cycles. A line that falls back before the window completes is treated as a false pulse. It is dropped, and a sticky status flag records the event.

The request has no enable or mask input. It stays asserted until the processor pulses an acknowledge. One continuous assertion of the line yields at most one request, and the line must return to inactive and rise again before another request can form. Internally a four-state controller sequences the work: idle, qualifying, pending (qualified while the line is still active) and waiting for release.

Top module: `nmi_qualifier`

## Requirements
- R1: After reset, `nmi_req` and `pulse_rejected` are 0, and they stay 0 until the line is driven.
- R2: Let L be the qualification length. With the line held active, `nmi_req` first reads 1 exactly SYNC_STAGES + L rising clock edges after the first edge that samples the line active. One edge earlier it still reads 0.
- R3: A pulse that is active for fewer than L synchronized cycles produces no request and sets `pulse_rejected`.
- R4: A pulse that is active for L or more synchronized cycles produces a request and leaves `pulse_rejected` at 0.
- R5: A `qual_len` value of 0 behaves the same as a value of 1.
- R6: Once set, `nmi_req` stays at 1 until `ack` is high at a clock edge. It then reads 0 after that edge, unless R8 applies.
- R7: After the request is acknowledged, a line that stays active raises no further request. The line must go inactive and rise again before another qualification can start.
- R8: If `ack` is high at the same edge where a new qualification completes, `nmi_req` remains 1.
- R9: `pulse_rejected` stays at 1 until `clr_reject` is high at a clock edge. If a rejection happens at that same edge, the flag stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| nmi_line | input | 1 | Asynchronous interrupt line (active high by default) |
| qual_len | input | QW | Required active cycles after the edge; 0 acts as 1 |
| ack | input | 1 | One-cycle acknowledge that clears the request |
| clr_reject | input | 1 | Clears the rejected-pulse flag |
| nmi_req | output | 1 | Latched non-maskable request |
| pulse_rejected | output | 1 | Sticky flag: a pulse failed qualification |

## Verification
The bench sweeps every qualification length from 0 to 5 against pulse widths from 1 to 7 cycles. This covers the boundary between a width one short of the window, which must be rejected, and a width exactly equal to it, which must be accepted. A long held assertion is timed edge by edge to pin the latency. The same held assertion, acknowledged while still active, shows that it does not re-trigger until released. An acknowledge aligned with a fresh qualification, and a clear aligned with a fresh rejection, tell apart the two priority orders of the set and clear paths.

// File: rtl/nmi_pkg.sv
package nmi_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_QUALIFY = 2'd1,
    ST_PENDING = 2'd2,
    ST_WAIT_RL = 2'd3
  } nmi_state_e;

endpackage

// File: rtl/nmi_sync.sv
module nmi_sync #(
  parameter int STAGES      = 2,
  parameter bit ACTIVE_HIGH = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_in,
  output logic lvl_out
);
  logic norm_in;
  logic [STAGES-1:0] chain_q;

  generate
    if (ACTIVE_HIGH) begin : g_pos
      assign norm_in = raw_in;
    end else begin : g_neg
      assign norm_in = ~raw_in;
    end
  endgenerate

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= norm_in;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], norm_in};
      end
    end
  endgenerate

  assign lvl_out = chain_q[STAGES-1];
endmodule

// File: rtl/nmi_edge_det.sv
module nmi_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic rise
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= lvl;
  end

  assign rise = lvl & ~prev_q;
endmodule

// File: rtl/nmi_qual_fsm.sv
module nmi_qual_fsm
  import nmi_pkg::*;
#(
  parameter int QW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lvl,
  input  logic          rise,
  input  logic [QW-1:0] qual_len,
  input  logic          ack,
  output logic          qual_done,
  output logic          qual_drop,
  output nmi_state_e    state
);
  localparam int CW = QW + 1;

  // Window length in cycles; a zero setting acts as a one-cycle window.
  function automatic logic [CW-1:0] eff_len(input logic [QW-1:0] l);
    return (l == '0) ? CW'(1) : {1'b0, l};
  endfunction

  // True once the cycle being counted closes the window.
  function automatic logic window_full(input logic [CW-1:0] seen,
                                       input logic [CW-1:0] need);
    return (seen >= need);
  endfunction

  nmi_state_e state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] need;

  assign need = eff_len(qual_len);

  always_comb begin
    state_d   = state_q;
    cnt_d     = cnt_q;
    qual_done = 1'b0;
    qual_drop = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (rise) begin
          if (window_full(CW'(1), need)) begin
            qual_done = 1'b1;
            state_d   = ST_PENDING;
          end else begin
            cnt_d   = CW'(1);
            state_d = ST_QUALIFY;
          end
        end
      end
      ST_QUALIFY: begin
        if (!lvl) begin
          qual_drop = 1'b1;
          cnt_d     = '0;
          state_d   = ST_IDLE;
        end else if (window_full(cnt_q + CW'(1), need)) begin
          qual_done = 1'b1;
          cnt_d     = '0;
          state_d   = ST_PENDING;
        end else begin
          cnt_d = cnt_q + CW'(1);
        end
      end
      ST_PENDING: begin
        if (!lvl)     state_d = ST_IDLE;
        else if (ack) state_d = ST_WAIT_RL;
      end
      ST_WAIT_RL: begin
        if (!lvl) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign state = state_q;
endmodule

// File: rtl/nmi_qualifier.sv
module nmi_qualifier
  import nmi_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int QW          = 4,
  parameter bit ACTIVE_HIGH = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          nmi_line,
  input  logic [QW-1:0] qual_len,
  input  logic          ack,
  input  logic          clr_reject,
  output logic          nmi_req,
  output logic          pulse_rejected
);
  logic       lvl_sync;
  logic       edge_rise;
  logic       qual_done;
  logic       qual_drop;
  nmi_state_e fsm_state;
  logic       req_q;
  logic       rej_q;

  nmi_sync #(.STAGES(SYNC_STAGES), .ACTIVE_HIGH(ACTIVE_HIGH)) u_sync (
    .clk(clk), .rst_n(rst_n), .raw_in(nmi_line), .lvl_out(lvl_sync)
  );

  nmi_edge_det u_edge (
    .clk(clk), .rst_n(rst_n), .lvl(lvl_sync), .rise(edge_rise)
  );

  nmi_qual_fsm #(.QW(QW)) u_fsm (
    .clk(clk), .rst_n(rst_n), .lvl(lvl_sync), .rise(edge_rise),
    .qual_len(qual_len), .ack(ack), .qual_done(qual_done),
    .qual_drop(qual_drop), .state(fsm_state)
  );

  // Set beats clear on both sticky bits.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= 1'b0;
      rej_q <= 1'b0;
    end else begin
      req_q <= qual_done | (req_q & ~ack);
      rej_q <= qual_drop | (rej_q & ~clr_reject);
    end
  end

  assign nmi_req        = req_q;
  assign pulse_rejected = rej_q;
endmodule

// File: rtl/nmi_qualifier_chk.sv
module nmi_qualifier_chk (
  input logic clk,
  input logic rst_n,
  input logic ack,
  input logic clr_reject,
  input logic lvl_sync,
  input logic qual_done,
  input logic qual_drop,
  input logic nmi_req,
  input logic pulse_rejected
);
  assert_req_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_req && !ack) |=> nmi_req);

  assert_ack_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !qual_done) |=> !nmi_req);

  assert_done_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    qual_done |=> nmi_req);

  assert_req_source_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nmi_req) |-> $past(qual_done));

  assert_done_needs_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
    qual_done |-> lvl_sync);

  assert_drop_flags_R3: assert property (@(posedge clk) disable iff (!rst_n)
    qual_drop |=> pulse_rejected);

  assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_rejected && !clr_reject) |=> pulse_rejected);

  assert_done_drop_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(qual_done && qual_drop));
endmodule

bind nmi_qualifier nmi_qualifier_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ack(ack), .clr_reject(clr_reject),
  .lvl_sync(lvl_sync), .qual_done(qual_done), .qual_drop(qual_drop),
  .nmi_req(nmi_req), .pulse_rejected(pulse_rejected)
);

// File: tb/sim_nmi_qualifier.sv
module sim_nmi_qualifier;
  localparam int SYNC = 2;
  localparam int QW   = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic nmi_line = 1'b0;
  logic [QW-1:0] qual_len = '0;
  logic ack = 1'b0;
  logic clr_reject = 1'b0;
  logic nmi_req, pulse_rejected;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  nmi_qualifier #(.SYNC_STAGES(SYNC), .QW(QW)) u0 (
    .clk(clk), .rst_n(rst_n), .nmi_line(nmi_line), .qual_len(qual_len),
    .ack(ack), .clr_reject(clr_reject), .nmi_req(nmi_req),
    .pulse_rejected(pulse_rejected)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input int w);
    nmi_line = 1'b1;
    repeat (w) @(negedge clk);
    nmi_line = 1'b0;
  endtask

  task automatic do_ack();
    ack = 1'b1; @(negedge clk); ack = 1'b0;
  endtask

  task automatic do_clr();
    clr_reject = 1'b1; @(negedge clk); clr_reject = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(4);
    chk("R1 req after reset", nmi_req, 1'b0);
    chk("R1 flag after reset", pulse_rejected, 1'b0);

    // R3 R4 R5: sweep of window length against pulse width
    for (int l = 0; l <= 5; l++) begin
      for (int w = 1; w <= 7; w++) begin
        int need;
        logic accept;
        need = (l == 0) ? 1 : l;
        accept = (w >= need);
        qual_len = QW'(l);
        @(negedge clk);
        pulse(w);
        idle(SYNC + 4);
        chk($sformatf("R4 R5 req L=%0d W=%0d", l, w), nmi_req, accept);
        chk($sformatf("R3 flag L=%0d W=%0d", l, w), pulse_rejected, ~accept);
        do_ack();
        chk("R6 ack clears req", nmi_req, 1'b0);
        do_clr();
        chk("R9 clr clears flag", pulse_rejected, 1'b0);
      end
    end

    // R2: latency of a held assertion, L=3
    qual_len = QW'(3);
    idle(2);
    nmi_line = 1'b1;
    idle(SYNC + 3 - 1);
    chk("R2 one edge early", nmi_req, 1'b0);
    idle(1);
    chk("R2 on time", nmi_req, 1'b1);

    // R6: held without ack; R7: no re-trigger while still active
    idle(6);
    chk("R6 held until ack", nmi_req, 1'b1);
    do_ack();
    chk("R6 cleared by ack", nmi_req, 1'b0);
    idle(10);
    chk("R7 no retrigger while held", nmi_req, 1'b0);
    nmi_line = 1'b0;
    idle(8);
    chk("R7 no request on release", nmi_req, 1'b0);
    chk("R7 release is not rejection", pulse_rejected, 1'b0);
    nmi_line = 1'b1;
    idle(SYNC + 5);
    chk("R7 reassert gives request", nmi_req, 1'b1);
    nmi_line = 1'b0;
    idle(6);
    chk("R6 req survives release", nmi_req, 1'b1);

    // R8: ack lands on the edge completing a new qualification
    nmi_line = 1'b1;
    idle(SYNC + 3 - 1);
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
    chk("R8 done beats ack", nmi_req, 1'b1);
    nmi_line = 1'b0;
    idle(4);
    do_ack();
    chk("R8 later ack clears", nmi_req, 1'b0);

    // R9: clear lands on the edge of a new rejection
    pulse(1);
    idle(SYNC + 4);
    chk("R9 flag set", pulse_rejected, 1'b1);
    idle(2);
    chk("R9 flag sticky", pulse_rejected, 1'b1);
    nmi_line = 1'b1;
    @(negedge clk);
    nmi_line = 1'b0;
    idle(2);
    clr_reject = 1'b1;
    @(negedge clk);
    clr_reject = 1'b0;
    chk("R9 set beats clear", pulse_rejected, 1'b1);
    do_clr();
    chk("R9 clear alone", pulse_rejected, 1'b0);
    chk("R3 short pulse no req", nmi_req, 1'b0);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule